// File: doc/BRIEF.md
# ADC Rail-Code Saturation Monitor

This block sits on the raw sample stream of a 16-bit converter that delivers offset-binary codes with no over-range pin of its own. It compares every strobed sample against the two end-of-scale codes and counts how many strobed samples in a row land on either of them. When that run reaches a length set at run time, the block raises a live saturation flag. It also keeps a sticky flag and a count of saturation events, and software can clear both.

A rail code is the converter's output for any input at or beyond full scale. Such a code can also be an honest in-range conversion, so a hit means "at or beyond full scale", not "strictly beyond". A run length of one suits high-frequency inputs, where clipping can show on a single isolated sample. A longer run length is trustworthy only when the input bandwidth is small next to Nyquist. Each strobed sample is also passed on in two's complement, registered, on the same cycle as the flag it produced.

Top module: `adc_clip_monitor`

## Requirements
- R1: A strobed sample equal to 16'h0000 (lower rail) counts as a rail hit.
- R2: A strobed sample equal to 16'hFFFE (upper rail, one below all-ones) counts as a rail hit. 16'hFFFF is an ordinary sample and breaks a run.
- R3: The run length rises by one on each strobed rail hit, whichever rail it hits, so lower and upper hits may mix within one run. A strobed non-rail sample returns the run length to zero. `sat_now` is high in the cycle after a strobed sample that leaves the run length at or above `run_len`, and low after one that leaves it below.
- R4: `run_len` of 1 flags a single isolated rail hit. `run_len` of 0 behaves as 1.
- R5: The run length saturates at 2^RUN_W-1 and does not wrap, so `sat_now` stays high through an arbitrarily long run.
- R6: `sat_sticky` sets on each rising edge of the qualified condition and clears only on `clr_sat`. If a clear and a new rising edge fall in the same cycle, the flag ends up set.
- R7: `sat_events` increments once on each rising edge of the qualified condition and saturates at all-ones (16'hFFFF by default).
- R8: `clr_sat` returns `sat_events` to zero. If a new rising edge arrives in the same cycle, the counter becomes 1.
- R9: Cycles with `in_valid` low leave the run length, `sat_now`, `sat_sticky` and `sat_events` unchanged, whatever the code on `in_code`.
- R10: `out_sample` is the strobed input with its MSB inverted (two's complement), and it is registered with one cycle of latency. `out_valid` is `in_valid` delayed by one cycle. `out_sample` holds its value while `out_valid` is low.
- R11: After an active-low synchronous reset, all outputs and the run length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_code | input | DATA_W | Raw offset-binary sample |
| run_len | input | RUN_W | Consecutive rail hits needed to flag saturation (0 acts as 1) |
| clr_sat | input | 1 | Clears the sticky flag and the event counter |
| out_valid | output | 1 | Strobe for out_sample |
| out_sample | output | DATA_W | Sample in two's complement |
| sat_now | output | 1 | Run of rail hits at or above run_len |
| sat_sticky | output | 1 | A saturation event has occurred since the last clear |
| sat_events | output | EVT_W | Saturating count of saturation events |

## Verification
The bench builds the block with RUN_W = 3 and EVT_W = 4 and leaves DATA_W at 16, so the rail codes are the real ones. The narrow run counter lets a run of twelve hits push the run length past its ceiling of 7 while `run_len` is 7, which exercises the no-wrap behaviour. The 4-bit event counter reaches its ceiling of 15 after twenty alternating hit/miss pairs, well inside the cycle budget.

// File: rtl/adc_clip_pkg.sv
// Package: shared types for the rail-code saturation monitor.
// Assumes: offset-binary samples, rails at the lowest code and one below all-ones.
package adc_clip_pkg;

    // Classification of one sample against the end-of-scale codes.
    typedef enum logic [1:0] {
        RAIL_NONE = 2'd0,
        RAIL_LOW  = 2'd1,
        RAIL_HIGH = 2'd2
    } rail_kind_e;

endpackage

// File: rtl/adc_rail_detect.sv
// Module: adc_rail_detect
// Classifies a raw offset-binary code as lower rail, upper rail or neither,
// and produces its two's-complement form. Purely combinational.
// Assumes: upper rail is all-ones minus one; all-ones is an ordinary code.
module adc_rail_detect
    import adc_clip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] code_i,
    output rail_kind_e        kind_o,
    output logic [DATA_W-1:0] tc_o
);

    localparam logic [DATA_W-1:0] LO_RAIL = '0;
    localparam logic [DATA_W-1:0] HI_RAIL = {{(DATA_W-1){1'b1}}, 1'b0};
    localparam logic [DATA_W-1:0] MSB_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

    // Compare against both rail codes.
    always_comb begin
        if (code_i == LO_RAIL)      kind_o = RAIL_LOW;
        else if (code_i == HI_RAIL) kind_o = RAIL_HIGH;
        else                        kind_o = RAIL_NONE;
    end

    // Offset binary to two's complement: invert the sign bit.
    assign tc_o = code_i ^ MSB_FLIP;

endmodule

// File: rtl/adc_run_qualifier.sv
// Module: adc_run_qualifier
// Counts consecutive strobed rail hits (either rail) with a saturating
// counter and registers the "run at or above threshold" flag. Flags the
// cycle in which the qualified condition rises.
// Assumes: a threshold of 0 is treated as 1.
module adc_run_qualifier #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             hit_i,
    input  logic [RUN_W-1:0] thresh_i,
    output logic             sat_q_o,
    output logic             rise_o
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] ONE     = RUN_W'(1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic [RUN_W-1:0] eff_thresh;
    logic             qual_d;

    // Next run length for a strobed sample: saturating increment or restart.
    always_comb begin
        if (hit_i) run_d = (run_q == RUN_MAX) ? RUN_MAX : run_q + ONE;
        else       run_d = '0;
    end

    // Threshold of zero behaves as one.
    assign eff_thresh = (thresh_i == '0) ? ONE : thresh_i;
    assign qual_d     = (run_d >= eff_thresh);
    assign rise_o     = valid_i && qual_d && !sat_q_o;

    // Run counter and live flag advance only on strobed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            sat_q_o <= 1'b0;
        end else if (valid_i) begin
            run_q   <= run_d;
            sat_q_o <= qual_d;
        end
    end

endmodule

// File: rtl/adc_sat_events.sv
// Module: adc_sat_events
// Sticky saturation flag and saturating event counter, both cleared by a
// clear pulse. A new event in the clear cycle takes precedence.
// Assumes: rise_i is high for exactly one cycle per event.
module adc_sat_events #(
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             clr_i,
    output logic             sticky_o,
    output logic [EVT_W-1:0] count_o
);

    localparam logic [EVT_W-1:0] CNT_MAX = '1;
    localparam logic [EVT_W-1:0] CNT_ONE = EVT_W'(1);

    // Sticky flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      sticky_o <= 1'b0;
        else if (rise_i) sticky_o <= 1'b1;
        else if (clr_i)  sticky_o <= 1'b0;
    end

    // Event counter: clear restarts at zero or one, otherwise saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count_o <= '0;
        else if (clr_i)                     count_o <= rise_i ? CNT_ONE : '0;
        else if (rise_i && count_o != CNT_MAX) count_o <= count_o + CNT_ONE;
    end

endmodule

// File: rtl/adc_clip_monitor.sv
// Module: adc_clip_monitor (top)
// Watches an offset-binary sample stream for end-of-scale codes, qualifies
// runs of them against a runtime threshold, keeps sticky and counted
// saturation status, and forwards each sample in two's complement with one
// cycle of latency, aligned with sat_now.
// Assumes: one sample per in_valid strobe; clr_sat is a single-cycle pulse.
module adc_clip_monitor
    import adc_clip_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RUN_W  = 8,
    parameter int EVT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_code,
    input  logic [RUN_W-1:0]  run_len,
    input  logic              clr_sat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic              sat_now,
    output logic              sat_sticky,
    output logic [EVT_W-1:0]  sat_events
);

    rail_kind_e        kind;
    logic [DATA_W-1:0] tc_code;
    logic              rail_hit;
    logic              sat_rise;

    adc_rail_detect #(.DATA_W(DATA_W)) detect_i (
        .code_i (in_code),
        .kind_o (kind),
        .tc_o   (tc_code)
    );

    assign rail_hit = (kind != RAIL_NONE);

    adc_run_qualifier #(.RUN_W(RUN_W)) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .hit_i    (rail_hit),
        .thresh_i (run_len),
        .sat_q_o  (sat_now),
        .rise_o   (sat_rise)
    );

    adc_sat_events #(.EVT_W(EVT_W)) events_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (sat_rise),
        .clr_i    (clr_sat),
        .sticky_o (sat_sticky),
        .count_o  (sat_events)
    );

    // Output stage: register the converted sample and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= tc_code;
        end
    end

endmodule

// File: rtl/adc_clip_monitor_chk.sv
// Module: adc_clip_monitor_chk
// Port-level properties of the saturation monitor, bound into the top.
module adc_clip_monitor_chk #(
    parameter int DATA_W = 16,
    parameter int RUN_W  = 8,
    parameter int EVT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_code,
    input logic              clr_sat,
    input logic              out_valid,
    input logic              sat_now,
    input logic              sat_sticky,
    input logic [EVT_W-1:0]  sat_events
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [EVT_W-1:0]  EVT_MAX  = '1;

    // R2: an all-ones strobed sample ends any run.
    a_r2_all_ones_breaks_run: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code == ALL_ONES) |=> !sat_now);

    // R6: sticky flag only drops on a clear.
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !clr_sat) |=> sat_sticky);

    // R7: counter holds at its ceiling without a clear.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_events == EVT_MAX && !clr_sat) |=> sat_events == EVT_MAX);

    // R7: without a clear, the counter moves by at most one.
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sat) |=> (sat_events == $past(sat_events) ||
                        sat_events == $past(sat_events) + EVT_W'(1)));

    // R9: idle cycles leave all saturation status untouched.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr_sat) |=> ($stable(sat_now) && $stable(sat_sticky) &&
                                     $stable(sat_events)));

    // R10: output strobe trails the input strobe by one cycle.
    a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind adc_clip_monitor adc_clip_monitor_chk #(
    .DATA_W (DATA_W),
    .RUN_W  (RUN_W),
    .EVT_W  (EVT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_code    (in_code),
    .clr_sat    (clr_sat),
    .out_valid  (out_valid),
    .sat_now    (sat_now),
    .sat_sticky (sat_sticky),
    .sat_events (sat_events)
);

// File: tb/adc_clip_monitor_tb_top.sv
// Bench for adc_clip_monitor: vector table walk, then directed corner cases.
module adc_clip_monitor_tb_top;

    localparam int DATA_W = 16;
    localparam int RUN_W  = 3;
    localparam int EVT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_code = '0;
    logic [RUN_W-1:0]  run_len = '0;
    logic              clr_sat = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_sample;
    logic              sat_now;
    logic              sat_sticky;
    logic [EVT_W-1:0]  sat_events;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    adc_clip_monitor #(.DATA_W(DATA_W), .RUN_W(RUN_W), .EVT_W(EVT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .run_len(run_len), .clr_sat(clr_sat), .out_valid(out_valid),
        .out_sample(out_sample), .sat_now(sat_now), .sat_sticky(sat_sticky),
        .sat_events(sat_events)
    );

    typedef struct packed {
        logic              v;
        logic [15:0]       code;
        logic [2:0]        n;
        logic              clr;
        logic              sn;
        logic              st;
        logic [3:0]        ev;
        logic              ov;
        logic [15:0]       os;
    } vec_t;

    // Inputs of one cycle and the outputs expected after that cycle's edge.
    localparam vec_t VECS [16] = '{
        '{1'b1, 16'h8000, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0000}, // R10 mid-scale
        '{1'b1, 16'h0000, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 16'h8000}, // R1 run 1 < 2
        '{1'b1, 16'hFFFE, 3'd2, 1'b0, 1'b1, 1'b1, 4'd1, 1'b1, 16'h7FFE}, // R2 R3 mixed run hits 2
        '{1'b1, 16'h0000, 3'd2, 1'b0, 1'b1, 1'b1, 4'd1, 1'b1, 16'h8000}, // R7 no second count
        '{1'b0, 16'h1234, 3'd2, 1'b0, 1'b1, 1'b1, 4'd1, 1'b0, 16'h8000}, // R9 idle, out holds
        '{1'b1, 16'hFFFF, 3'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 16'h7FFF}, // R2 all-ones breaks
        '{1'b1, 16'h0000, 3'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 16'h8000}, // R3 restart at 1
        '{1'b1, 16'h4000, 3'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 16'hC000}, // R3 reset run
        '{1'b1, 16'hFFFE, 3'd1, 1'b0, 1'b1, 1'b1, 4'd2, 1'b1, 16'h7FFE}, // R4 single hit
        '{1'b1, 16'h0001, 3'd1, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 16'h8001}, // R3 near-rail miss
        '{1'b1, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b1, 16'h8000}, // R4 zero acts as one
        '{1'b1, 16'h7FFF, 3'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 16'hFFFF}, // R6 R8 clear
        '{1'b1, 16'hFFFE, 3'd1, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 16'h7FFE}, // R6 R8 event beats clear
        '{1'b1, 16'h8000, 3'd1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 16'h0000}, // R6 sticky holds
        '{1'b0, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 16'h0000}, // R9 idle rail code
        '{1'b1, 16'hC000, 3'd1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 16'h4000}  // R10 negative
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, return at the next falling edge.
    task automatic step(input logic v, input logic [15:0] c, input logic [2:0] n, input logic cl);
        in_valid = v; in_code = c; run_len = n; clr_sat = cl;
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R11: reset state
        chk("R11 sat_now", 32'(sat_now), 0);
        chk("R11 sat_sticky", 32'(sat_sticky), 0);
        chk("R11 sat_events", 32'(sat_events), 0);
        chk("R11 out_valid", 32'(out_valid), 0);
        chk("R11 out_sample", 32'(out_sample), 0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            step(VECS[i].v, VECS[i].code, VECS[i].n, VECS[i].clr);
            chk($sformatf("vec%0d sat_now R3", i), 32'(sat_now), 32'(VECS[i].sn));
            chk($sformatf("vec%0d sat_sticky R6", i), 32'(sat_sticky), 32'(VECS[i].st));
            chk($sformatf("vec%0d sat_events R7", i), 32'(sat_events), 32'(VECS[i].ev));
            chk($sformatf("vec%0d out_valid R10", i), 32'(out_valid), 32'(VECS[i].ov));
            chk($sformatf("vec%0d out_sample R10", i), 32'(out_sample), 32'(VECS[i].os));
        end

        // R5: run of twelve with threshold 7 pushes the 3-bit run past its ceiling.
        step(1'b1, 16'h2000, 3'd7, 1'b1);
        chk("R8 cleared", 32'(sat_events), 0);
        for (int k = 1; k <= 12; k++) begin
            step(1'b1, 16'hFFFE, 3'd7, 1'b0);
            chk($sformatf("R5 hit %0d sat_now", k), 32'(sat_now), (k >= 7) ? 1 : 0);
        end
        chk("R5 single event", 32'(sat_events), 1);
        step(1'b1, 16'h1000, 3'd7, 1'b0);
        chk("R5 run ends", 32'(sat_now), 0);

        // R7: twenty events saturate a 4-bit counter at 15.
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 16'h0000, 3'd1, 1'b0);
            step(1'b1, 16'h5555, 3'd1, 1'b0);
        end
        chk("R7 saturated", 32'(sat_events), 15);
        chk("R6 sticky after burst", 32'(sat_sticky), 1);

        // R11: reset in the middle of a run.
        step(1'b1, 16'h0000, 3'd1, 1'b0);
        rst_n = 1'b0;
        step(1'b0, 16'h0000, 3'd1, 1'b0);
        chk("R11 mid reset sat_now", 32'(sat_now), 0);
        chk("R11 mid reset events", 32'(sat_events), 0);
        chk("R11 mid reset sticky", 32'(sat_sticky), 0);
        rst_n = 1'b1;
        step(1'b1, 16'h0000, 3'd2, 1'b0);
        chk("R11 run restarted from zero", 32'(sat_now), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule